// File: doc/BRIEF.md
# Dual-Access Register-Mapped Data Queue

This block holds one first-in first-out queue of 32-bit words that two kinds of client share. Software reaches it through a word-addressed slave port. Writes take effect at once. A read returns its data on the clock after the read strobe, marked by a valid pulse. Hardware reaches it through two strobe-based paths. The sink pushes the word on its data input in any cycle where its push strobe is high. The source always shows the oldest word on its output, and a pop strobe removes that word.

The register window gives software several controls. It holds a configuration word that is only stored and read back. It reports the empty flag, the full flag and the fill level. It has a push location, a pop location that returns the head word, and a clear command that does not persist. When both clients try the same operation in the same cycle, the hardware client takes priority. The capacity is set by the `DEPTH` parameter and must be a power of two.

Top module: `regfifo_channel`

## Requirements
- R1: A write to word address 0 stores the write data, and a read of address 0 returns the value most recently written there (0 after reset).
- R2: A read of address 1 returns 1 when the queue holds no entries and 0 otherwise; the source's `hw_avail` output is high exactly when the queue is not empty.
- R3: A read of address 2 returns 1 when the queue holds `DEPTH` entries and 0 otherwise.
- R4: A read of address 3 returns the number of entries held, modulo `DEPTH`, so a completely full queue reads 0.
- R5: A write to address 4 appends the write data to the tail of the queue.
- R6: A read of address 5 returns the head entry and removes it. Read data for any address appears one clock after the read strobe, with `sw_rvalid` high for that one clock.
- R7: A write of exactly 1 to address 6 empties the queue, and other values written there have no effect. A clear takes precedence over any push or pop in the same cycle.
- R8: When `hw_push` is high at a clock edge, `hw_push_data` is appended to the tail of the queue.
- R9: `hw_pop_data` shows the head entry while the queue is not empty, before any pop, and `hw_pop` high at a clock edge removes that entry.
- R10: A push is ignored while the queue is full, even if a pop happens in the same cycle. A pop is ignored while the queue is empty, and a read of address 5 then returns 0.
- R11: When `hw_push` and a software write to address 4 occur in the same cycle, only the hardware word is appended.
- R12: When `hw_pop` and a software read of address 5 occur in the same cycle on a non-empty queue, only one entry is removed. The hardware port takes it, and the software read returns 0.
- R13: An accepted push and an accepted pop in the same cycle leave the level unchanged and keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_addr | input | 4 | Word address of the register window |
| sw_read | input | 1 | Software read strobe |
| sw_write | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, valid with sw_rvalid |
| sw_rvalid | output | 1 | Read data valid, one clock after sw_read |
| hw_push | input | 1 | Hardware sink push strobe |
| hw_push_data | input | 32 | Hardware sink data |
| hw_pop | input | 1 | Hardware source pop strobe |
| hw_pop_data | output | 32 | Head entry, shown ahead of the pop |
| hw_avail | output | 1 | Queue not empty |

## Verification
The collisions that matter happen when the two clients reach the queue in the same cycle. The first case is a hardware push in the cycle of a software push. The second is a hardware pop in the cycle of a software pop. The third is any push landing in the cycle of a pop or of a clear. The bench raises the strobes on both sides at the same falling edge. A behavioural queue model then decides which word is appended or removed, and the bench compares the source output, the availability flag and every software read result against that model on every clock.

// File: rtl/regfifo_pkg.sv
// Package: shared constants for the register-mapped data queue.
// Assumes a 4-bit word address; offsets are fixed by the software interface.
package regfifo_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CONFIG = 4'd0,
        RA_EMPTY  = 4'd1,
        RA_FULL   = 4'd2,
        RA_LEVEL  = 4'd3,
        RA_PUSH   = 4'd4,
        RA_POP    = 4'd5,
        RA_CLEAR  = 4'd6
    } reg_addr_t;
endpackage

// File: rtl/regfifo_store.sv
// Module: regfifo_store
// Word array with one synchronous write port and one asynchronous read port.
// Assumes the caller keeps addresses in range; contents are not reset.
module regfifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per accepted push.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the head word without waiting for a pop.
    always_comb begin
        rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/regfifo_ctrl.sv
// Module: regfifo_ctrl
// Pointers, level counter, full flag and the arbitration between the two ports.
// Assumes DEPTH is a power of two so the pointers wrap by themselves.
// The level counter is log2(DEPTH) bits wide; a separate full flag tells
// full apart from empty.
module regfifo_ctrl #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_push,
    input  logic [DATA_W-1:0] hw_pdata,
    input  logic              sw_push,
    input  logic [DATA_W-1:0] sw_pdata,
    input  logic              hw_pop,
    input  logic              sw_pop,
    input  logic              clr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_addr,
    output logic              empty,
    output logic              full,
    output logic [PTR_W-1:0]  level
);
    logic [PTR_W-1:0] wr_ptr, rd_ptr, count;
    logic             full_q;
    logic             push_req, push_ok, pop_ok;

    // Pick the pushing port (hardware first) and gate pushes and pops by the flags.
    always_comb begin
        push_req = hw_push | sw_push;
        push_ok  = push_req && !full_q && !clr;
        pop_ok   = (hw_pop | sw_pop) && !empty && !clr;
        wr_data  = hw_push ? hw_pdata : sw_pdata;
    end

    // Empty when the counter is zero and the full flag is clear.
    always_comb begin
        empty = !full_q && (count == '0);
    end

    // Advance the pointers, the counter and the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            full_q <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok) begin
                count  <= count + 1'b1;
                full_q <= (count == PTR_W'(DEPTH - 1));
            end else if (pop_ok && !push_ok) begin
                count  <= count - 1'b1;
                full_q <= 1'b0;
            end
        end
    end

    assign wr_en   = push_ok;
    assign wr_addr = wr_ptr;
    assign rd_addr = rd_ptr;
    assign full    = full_q;
    assign level   = count;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !pop_ok && !clr) |=> (full_q && $stable(count))); // R10
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_req) |=> empty); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && count == '0)); // R7
    AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> ($stable(count) && !full_q)); // R13
    AST_HW_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_push && sw_push) |-> (wr_data == hw_pdata)); // R11
endmodule

// File: rtl/regfifo_regs.sv
// Module: regfifo_regs
// Decodes the software window: configuration storage, status reads, push,
// pop and clear. Read data is registered, so it arrives one clock after the strobe.
// Assumes the hardware pop strobe is visible so that software pops can yield to it.
module regfifo_regs #(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [regfifo_pkg::ADDR_W-1:0] addr,
    input  logic                      rd,
    input  logic                      wr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      empty,
    input  logic                      full,
    input  logic [PTR_W-1:0]          level,
    input  logic [DATA_W-1:0]         head,
    input  logic                      hw_pop,
    output logic [DATA_W-1:0]         rdata,
    output logic                      rvalid,
    output logic                      sw_push,
    output logic                      sw_pop,
    output logic                      clr
);
    import regfifo_pkg::*;

    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] rd_mux;

    // Turn window writes and pop reads into single-cycle commands.
    always_comb begin
        sw_push = wr && (addr == RA_PUSH);
        clr     = wr && (addr == RA_CLEAR) && (wdata == DATA_W'(1));
        sw_pop  = rd && (addr == RA_POP);
    end

    // Pick the read value; a pop that is denied returns zero.
    always_comb begin
        rd_mux = '0;
        case (addr)
            RA_CONFIG: rd_mux = cfg_q;
            RA_EMPTY:  rd_mux = DATA_W'(empty);
            RA_FULL:   rd_mux = DATA_W'(full);
            RA_LEVEL:  rd_mux = DATA_W'(level);
            RA_POP:    rd_mux = (!empty && !hw_pop) ? head : '0;
            default:   rd_mux = '0;
        endcase
    end

    // Hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr && addr == RA_CONFIG) begin
            cfg_q <= wdata;
        end
    end

    // Register read data and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? rd_mux : '0;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid); // R6
    AST_POP_DENIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == RA_POP && (empty || hw_pop)) |=> (rdata == '0)); // R12
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == RA_EMPTY && empty) |=> (rdata == DATA_W'(1))); // R2
endmodule

// File: rtl/regfifo_channel.sv
// Module: regfifo_channel
// Top of the dual-access data queue: joins the register window, the control
// and the storage array. Assumes DEPTH is a power of two, at least 2.
module regfifo_channel #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        sw_addr,
    input  logic              sw_read,
    input  logic              sw_write,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    output logic              sw_rvalid,
    input  logic              hw_push,
    input  logic [DATA_W-1:0] hw_push_data,
    input  logic              hw_pop,
    output logic [DATA_W-1:0] hw_pop_data,
    output logic              hw_avail
);
    logic              sw_push, sw_pop, clr;
    logic              wr_en, empty, full;
    logic [PTR_W-1:0]  wr_addr, rd_addr, level;
    logic [DATA_W-1:0] wr_data, head;

    regfifo_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(sw_addr), .rd(sw_read), .wr(sw_write),
        .wdata(sw_wdata), .empty(empty), .full(full), .level(level),
        .head(head), .hw_pop(hw_pop), .rdata(sw_rdata), .rvalid(sw_rvalid),
        .sw_push(sw_push), .sw_pop(sw_pop), .clr(clr)
    );

    regfifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_push(hw_push), .hw_pdata(hw_push_data),
        .sw_push(sw_push), .sw_pdata(sw_wdata), .hw_pop(hw_pop), .sw_pop(sw_pop),
        .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .empty(empty), .full(full), .level(level)
    );

    regfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(head)
    );

    assign hw_pop_data = head;
    assign hw_avail    = !empty;

    AST_SOURCE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_push && !full && !clr) |=> hw_avail); // R8
endmodule

// File: tb/sim_regfifo_channel.sv
module sim_regfifo_channel;
    localparam int DW    = 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    sw_addr = '0;
    logic          sw_read = 1'b0, sw_write = 1'b0;
    logic [DW-1:0] sw_wdata = '0;
    logic [DW-1:0] sw_rdata;
    logic          sw_rvalid;
    logic          hw_push = 1'b0;
    logic [DW-1:0] hw_push_data = '0;
    logic          hw_pop = 1'b0;
    logic [DW-1:0] hw_pop_data;
    logic          hw_avail;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    regfifo_channel #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_read(sw_read),
        .sw_write(sw_write), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .sw_rvalid(sw_rvalid), .hw_push(hw_push), .hw_push_data(hw_push_data),
        .hw_pop(hw_pop), .hw_pop_data(hw_pop_data), .hw_avail(hw_avail)
    );

    always #5 clk = ~clk;

    // Behavioural reference model.
    logic [DW-1:0] q[$];
    logic [DW-1:0] m_cfg = '0;
    logic          m_rv = 1'b0;
    logic [DW-1:0] m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_cfg = '0;
            m_rv  = 1'b0;
            m_rd  = '0;
        end else begin
            automatic bit m_empty = (q.size() == 0);
            automatic bit m_full  = (q.size() == DEPTH);
            automatic bit clr = sw_write && sw_addr == 4'd6 && sw_wdata == 32'd1;
            automatic bit popd = 1'b0;
            m_rv = sw_read;
            m_rd = '0;
            if (sw_read) begin
                case (sw_addr)
                    4'd0: m_rd = m_cfg;
                    4'd1: m_rd = DW'(m_empty);
                    4'd2: m_rd = DW'(m_full);
                    4'd3: m_rd = DW'(q.size() % DEPTH);
                    4'd5: m_rd = (!m_empty && !hw_pop) ? q[0] : '0;
                    default: m_rd = '0;
                endcase
            end
            if (sw_write && sw_addr == 4'd0) m_cfg = sw_wdata;
            if (clr) begin
                q.delete();
            end else begin
                if (!m_empty && (hw_pop || (sw_read && sw_addr == 4'd5))) popd = 1'b1;
                if (!m_full) begin
                    if (hw_push) q.push_back(hw_push_data);
                    else if (sw_write && sw_addr == 4'd4) q.push_back(sw_wdata);
                end
                if (popd) void'(q.pop_front());
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " R6 rvalid"}, DW'(sw_rvalid), DW'(m_rv));
            if (m_rv) check({cur_req, " rdata"}, sw_rdata, m_rd);
            check({cur_req, " R2 avail"}, DW'(hw_avail), DW'(q.size() != 0));
            if (q.size() != 0) check({cur_req, " R9 head"}, hw_pop_data, q[0]);
        end
    end

    task automatic sw_rd(input logic [3:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        sw_addr = a; sw_read = 1'b1;
        @(negedge clk);
        sw_read = 1'b0;
        check(tag, sw_rdata, exp);
    endtask

    task automatic sw_wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sw_addr = a; sw_wdata = d; sw_write = 1'b1;
        @(negedge clk);
        sw_write = 1'b0;
    endtask

    task automatic hw_wr(input logic [DW-1:0] d);
        @(negedge clk);
        hw_push = 1'b1; hw_push_data = d;
        @(negedge clk);
        hw_push = 1'b0;
    endtask

    task automatic hw_rd(input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        check(tag, hw_pop_data, exp);
        hw_pop = 1'b1;
        @(negedge clk);
        hw_pop = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 R3 R4 reset state
        cur_req = "R1";
        sw_rd(4'd0, 32'd0, "R1 config after reset");
        cur_req = "R2";
        sw_rd(4'd1, 32'd1, "R2 empty after reset");
        cur_req = "R3";
        sw_rd(4'd2, 32'd0, "R3 not full after reset");
        cur_req = "R4";
        sw_rd(4'd3, 32'd0, "R4 level after reset");
        // R1 config readback
        cur_req = "R1";
        sw_wr(4'd0, 32'hA5C3_1234);
        sw_rd(4'd0, 32'hA5C3_1234, "R1 config readback");
        // R5 software push, R6 software pop
        cur_req = "R5";
        sw_wr(4'd4, 32'h1111_0001);
        sw_wr(4'd4, 32'h1111_0002);
        sw_wr(4'd4, 32'h1111_0003);
        sw_rd(4'd3, 32'd3, "R5 level after three pushes");
        sw_rd(4'd1, 32'd0, "R2 not empty");
        cur_req = "R6";
        sw_rd(4'd5, 32'h1111_0001, "R6 pop first");
        sw_rd(4'd5, 32'h1111_0002, "R6 pop second");
        sw_rd(4'd3, 32'd1, "R6 level after pops");
        sw_rd(4'd5, 32'h1111_0003, "R6 pop third");
        // R10 pop while empty
        cur_req = "R10";
        sw_rd(4'd5, 32'd0, "R10 pop empty returns zero");
        hw_rd(hw_pop_data, "R10 hw pop empty");
        sw_rd(4'd3, 32'd0, "R10 level after empty pops");
        // R8 hardware push, R9 show-ahead and pop
        cur_req = "R8";
        for (int i = 0; i < 4; i++) hw_wr(32'hBEEF_0000 + i);
        sw_rd(4'd3, 32'd4, "R8 level after hw pushes");
        cur_req = "R9";
        hw_rd(32'hBEEF_0000, "R9 show-ahead head 0");
        hw_rd(32'hBEEF_0001, "R9 show-ahead head 1");
        // R13 simultaneous push and pop
        cur_req = "R13";
        @(negedge clk);
        hw_push = 1'b1; hw_push_data = 32'hC0DE_0013; hw_pop = 1'b1;
        @(negedge clk);
        hw_push = 1'b0; hw_pop = 1'b0;
        sw_rd(4'd3, 32'd2, "R13 level unchanged");
        // R11 hardware push wins
        cur_req = "R11";
        @(negedge clk);
        hw_push = 1'b1; hw_push_data = 32'hAAAA_0011;
        sw_addr = 4'd4; sw_wdata = 32'h5555_0011; sw_write = 1'b1;
        @(negedge clk);
        hw_push = 1'b0; sw_write = 1'b0;
        sw_rd(4'd3, 32'd3, "R11 one entry added");
        // R12 hardware pop wins
        cur_req = "R12";
        @(negedge clk);
        hw_pop = 1'b1; sw_addr = 4'd5; sw_read = 1'b1;
        @(negedge clk);
        hw_pop = 1'b0; sw_read = 1'b0;
        check("R12 sw pop denied", sw_rdata, 32'd0);
        sw_rd(4'd3, 32'd2, "R12 one entry removed");
        hw_rd(32'hC0DE_0013, "R12 order kept");
        hw_rd(32'hAAAA_0011, "R11 hw word stored");
        // R3 R4 R10 fill to full
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) hw_wr(32'hF000_0000 + i);
        sw_rd(4'd2, 32'd1, "R3 full");
        cur_req = "R4";
        sw_rd(4'd3, 32'd0, "R4 full level wraps to 0");
        cur_req = "R10";
        hw_wr(32'hDEAD_DEAD);
        sw_wr(4'd4, 32'hDEAD_BEEF);
        @(negedge clk);
        hw_push = 1'b1; hw_push_data = 32'hDEAD_0001; hw_pop = 1'b1;
        @(negedge clk);
        hw_push = 1'b0; hw_pop = 1'b0;
        sw_rd(4'd3, 32'd15, "R10 push while full ignored");
        // R7 clear
        cur_req = "R7";
        sw_wr(4'd6, 32'd2);
        sw_rd(4'd3, 32'd15, "R7 clear with other value ignored");
        @(negedge clk);
        sw_addr = 4'd6; sw_wdata = 32'd1; sw_write = 1'b1;
        hw_push = 1'b1; hw_push_data = 32'h7777_7777;
        @(negedge clk);
        sw_write = 1'b0; hw_push = 1'b0;
        sw_rd(4'd1, 32'd1, "R7 empty after clear");
        sw_rd(4'd3, 32'd0, "R7 level after clear");
        check("R7 source empty", DW'(hw_avail), 32'd0);
        sw_wr(4'd4, 32'h0BAD_F00D);
        sw_rd(4'd5, 32'h0BAD_F00D, "R7 queue usable after clear");
        sw_rd(4'd0, 32'hA5C3_1234, "R1 config kept");
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule